// File: doc/BRIEF.md
# Bit-Programmable 16-Line Digital I/O Port

This block is a sixteen-line general-purpose I/O port. A host reaches it through a small byte-wide register window. Each line has its own direction bit. Two data bytes hold the values driven onto output lines. Reads of the data bytes return the levels actually present on the pins, after a two-flop synchronizer. The block drives pin values and per-line output enables. The pad tristate is built outside the block from those enables.

A legacy alias at window offset 0 gives a fixed-direction view of the port. A write to it lands in the low data byte, exactly as a write to offset 4 would. A read from it returns the synchronized levels of lines 8 to 15. This alias only makes sense while lines 0–7 are outputs and lines 8–15 are inputs. For that reason the two direction bytes come out of reset with opposite values.

A route input lets line 0 carry an external pulse-per-second signal instead of its data bit. While routed, line 0 is forced to drive.

Top module: `gpio16_port`

## Requirements
- R1: After reset, both data bytes are 00h, pin_oe is 16'h00FF and pin_out is 16'h0000.
- R2: The direction bytes sit at offset 6 (lines 0–7) and offset 7 (lines 8–15), with a 1 meaning output. pin_oe follows them. On an output line, pin_out carries the stored data bit, which is written at offset 4 (lines 0–7) or offset 5 (lines 8–15).
- R3: A data write (offset 4, 5 or 0) leaves the stored bit of every line that is an input at that moment unchanged. This holds even if the line is later made an output.
- R4: Reads at offsets 4 and 5 return the pin levels of lines 0–7 and 8–15. A level present at a clock edge is returned after two further edges.
- R5: Reads at offsets 6 and 7 return the direction bytes.
- R6: A write at offset 0 updates the low data byte with the same input-line masking as a write at offset 4.
- R7: A read at offset 0 returns the synchronized levels of lines 8–15.
- R8: While pps_route is 1, pin_out[0] equals pps_in and pin_oe[0] is 1, whatever the direction bit. While pps_route is 0, line 0 follows its data and direction bits.
- R9: Offsets 1, 2 and 3 read as 00h, and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 3 | Register offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |
| pps_route | input | 1 | 1 routes pps_in onto line 0 |
| pps_in | input | 1 | Pulse-per-second signal |
| pin_in | input | 16 | Levels sensed at the pins |
| pin_out | output | 16 | Values to drive on the pins |
| pin_oe | output | 16 | Per-line output enable |

## Verification
The hardest case to reach from the ports is a write that must be dropped. The line is an input, so the dropped bit cannot be seen at the time of the write. To expose it, the stimulus writes ones to a byte of input lines, then turns some of those lines into outputs. pin_out must then still show zero. The same method is used through the legacy alias. Readback is modelled as a loop in which output lines return their own drive and input lines return an external pattern. Each read waits out the synchronizer first.

// File: rtl/gpio16_port.sv
module gpio16_port #(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             pps_route,
  input  logic             pps_in,
  input  logic [LINES-1:0] pin_in,
  output logic [LINES-1:0] pin_out,
  output logic [LINES-1:0] pin_oe
);
  localparam logic [LINES-1:0] DIR_RST = {{(LINES-8){1'b0}}, 8'hFF};

  logic [LINES-1:0] dat_q, dir_q, meta_q, sync_q;

  wire wr_lo  = bus_wr && (bus_addr == 3'd4 || bus_addr == 3'd0);
  wire wr_hi  = bus_wr && bus_addr == 3'd5;
  wire wr_dlo = bus_wr && bus_addr == 3'd6;
  wire wr_dhi = bus_wr && bus_addr == 3'd7;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_q  <= '0;
      dir_q  <= DIR_RST;
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      if (wr_lo)  dat_q[7:0]  <= (dat_q[7:0]  & ~dir_q[7:0])  | (bus_wdata & dir_q[7:0]);
      if (wr_hi)  dat_q[15:8] <= (dat_q[15:8] & ~dir_q[15:8]) | (bus_wdata & dir_q[15:8]);
      if (wr_dlo) dir_q[7:0]  <= bus_wdata;
      if (wr_dhi) dir_q[15:8] <= bus_wdata;
    end
  end

  assign pin_out = {dat_q[LINES-1:1], pps_route ? pps_in : dat_q[0]};
  assign pin_oe  = {dir_q[LINES-1:1], pps_route | dir_q[0]};

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = sync_q[15:8];
      3'd4:    bus_rdata = sync_q[7:0];
      3'd5:    bus_rdata = sync_q[15:8];
      3'd6:    bus_rdata = dir_q[7:0];
      3'd7:    bus_rdata = dir_q[15:8];
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/gpio16_port_chk.sv
module gpio16_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        pps_route,
  input logic        pps_in,
  input logic [15:0] pin_in,
  input logic [15:0] pin_out,
  input logic [15:0] pin_oe
);
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  AST_PPS_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    pps_route |-> (pin_oe[0] && pin_out[0] == pps_in)); // R8
  AST_INPUT_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4 && pin_oe[7:1] == 7'h00) |=> $stable(pin_out[7:1])); // R3
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && bus_addr == 3'd4) |-> bus_rdata == $past(pin_in[7:0], 2)); // R4
  AST_ALIAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && pin_oe[7:1] == 7'h7F) |=> pin_out[7:1] == $past(bus_wdata[7:1])); // R6
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd6) |=> pin_oe[7:1] == $past(bus_wdata[7:1])); // R2
endmodule

bind gpio16_port gpio16_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pps_route(pps_route),
  .pps_in(pps_in), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio16_port_tb_top.sv
module gpio16_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, pps_route = 1'b0, pps_in = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, rv;
  logic [15:0] ext = '0, pin_out, pin_oe, pin_in;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio16_port dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pps_route(pps_route), .pps_in(pps_in),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    repeat (3) @(negedge clk);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    chk("R1 pin_oe", pin_oe, 16'h00FF);
    chk("R1 pin_out", pin_out, 16'h0000);
    rd(3'd6, rv); chk("R5 dir lo", {8'h0, rv}, 16'h00FF);
    rd(3'd7, rv); chk("R5 dir hi", {8'h0, rv}, 16'h0000);
  endtask

  task automatic t_output;
    wr(3'd4, 8'hA5);
    chk("R2 low drive", pin_out, 16'h00A5);
    rd(3'd4, rv); chk("R4 read lo", {8'h0, rv}, 16'h00A5);
  endtask

  task automatic t_input;
    ext = 16'h3C00;
    rd(3'd5, rv); chk("R4 read hi", {8'h0, rv}, 16'h003C);
    wr(3'd5, 8'hFF);
    wr(3'd7, 8'h0F);
    chk("R2 oe hi", pin_oe, 16'h0FFF);
    chk("R3 dropped hi", pin_out, 16'h00A5);
    rd(3'd7, rv); chk("R5 dir hi rb", {8'h0, rv}, 16'h000F);
    wr(3'd5, 8'h03);
    chk("R2 hi drive", pin_out, 16'h03A5);
    wr(3'd5, 8'h00);
    wr(3'd7, 8'h00);
  endtask

  task automatic t_alias;
    wr(3'd0, 8'h5A);
    chk("R6 alias write", pin_out, 16'h005A);
    rd(3'd4, rv); chk("R6 alias in lo byte", {8'h0, rv}, 16'h005A);
    ext = 16'hC300;
    rd(3'd0, rv); chk("R7 alias read", {8'h0, rv}, 16'h00C3);
    wr(3'd6, 8'h0F);
    wr(3'd0, 8'hFF);
    wr(3'd6, 8'hFF);
    chk("R3 alias masked", pin_out, 16'h005F);
  endtask

  task automatic t_pps;
    wr(3'd4, 8'h00);
    wr(3'd6, 8'hFE);
    @(negedge clk); pps_route = 1'b1; pps_in = 1'b1; #1;
    chk("R8 pps high", {14'h0, pin_oe[0], pin_out[0]}, 16'h0003);
    pps_in = 1'b0; #1;
    chk("R8 pps low", {14'h0, pin_oe[0], pin_out[0]}, 16'h0002);
    pps_route = 1'b0; #1;
    chk("R8 unrouted", {14'h0, pin_oe[0], pin_out[0]}, 16'h0000);
    wr(3'd6, 8'hFF);
  endtask

  task automatic t_unmapped;
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    chk("R9 no out change", pin_out, 16'h0000);
    chk("R9 no oe change", pin_oe, 16'h00FF);
    for (int a = 1; a < 4; a++) begin
      rd(3'(a), rv); chk("R9 reads zero", {8'h0, rv}, 16'h0000);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_output(); t_input(); t_alias(); t_pps(); t_unmapped();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule